// File: doc/BRIEF.md
# Five-Source Interrupt Enable Controller

This block sits beside a small 8-bit CPU core. It gathers interrupt requests from five sources: two external pins, two timer overflow flags and a serial port. It filters them through a software-written enable register that includes a master enable, and through a second register that places each source at one of two priority levels. The highest-ranked eligible request is presented to the core as a request line with a 16-bit vector address. When the core acknowledges, the block marks that priority level as in service.

Raw requests are captured only on the machine-cycle strobe. The two timer flags go through one extra machine cycle of delay, because an overflow flag is raised late in the cycle in which the overflow happens and is polled in the next one. A high-level request may interrupt a low-level handler. Nothing interrupts a high-level handler. An end-of-service pulse retires the most recently entered level.

Top module: `irq_enable_ctrl`

## Requirements
- R1: After reset the enable register and the priority register read 0x00 and `irq_req` is low.
- R2: Source indices are 0 = external 0, 1 = timer 0, 2 = external 1, 3 = timer 1, 4 = serial. Enable register (`reg_sel`=0) bit 7 is the master enable and bits 4..0 are the source enables by index. Priority register (`reg_sel`=1) bits 4..0 set each source to high (1) or low (0). Written bits read back unchanged on `reg_rdata`.
- R3: Enable bits 6 and 5 and priority bits 7..5 ignore writes and always read 0.
- R4: While the master enable is 0, `irq_req` stays low whatever the source enables and requests are.
- R5: A source whose enable bit is 0 never produces a request. A source whose enable bit is 1, with the master enable set, may produce one.
- R6: Among eligible requests of one level, the lowest index wins, and `irq_vec` = 0x0003 + 8 × index (0x0003, 0x000B, 0x0013, 0x001B, 0x0023).
- R7: An eligible high-level request wins over any low-level request, whatever their indices.
- R8: Requests from external and serial sources are seen one strobe after they are applied. Timer requests are seen only after the second strobe, and they stay visible for one strobe after they are removed.
- R9: Acknowledging a request (`irq_ack` while `irq_req` is high) puts its level in service. With low in service, only high requests are presented. With high in service, no request is presented.
- R10: `eos` retires the high level if it is in service, and otherwise the low level.
- R11: An acknowledge clears the captured request of the granted source until the next strobe. If the acknowledge coincides with a strobe, the clear wins.
- R12: `irq_ack` while `irq_req` is low has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cyc_stb | input | 1 | Machine-cycle strobe; requests are captured on it |
| reg_we | input | 1 | Register write enable |
| reg_sel | input | 1 | 0 selects enable register, 1 selects priority register |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data of the selected register |
| src_req | input | 5 | Raw requests by source index |
| irq_req | output | 1 | Interrupt request to the core |
| irq_vec | output | 16 | Vector address of the presented request |
| irq_ack | input | 1 | Core acknowledges the presented request |
| eos | input | 1 | End of service of the current handler |

## Verification
Two functions can fall in the same cycle. The first is the acknowledge clearing the granted source's captured request. The second is the strobe recapturing that same request from a raw input that is still high. The bench drives `irq_ack` and `cyc_stb` in one cycle with the raw request held. It then retires the level with `eos` and expects `irq_req` to stay low until the following strobe brings the request back. Sweeps over all request patterns against every priority setting, and against every enable setting, compare the vector with one computed arithmetically.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    localparam int NSRC    = 5;
    localparam int IDXW    = 3;
    localparam int VECW    = 16;
    localparam int REGW    = 8;
    localparam int GLB_BIT = 7;
    localparam logic [NSRC-1:0] TMR_MASK = 5'b01010;
    localparam logic [VECW-1:0] VEC_BASE = 16'h0003;
    localparam logic [VECW-1:0] VEC_STEP = 16'h0008;

    typedef logic [NSRC-1:0] src_vec_t;

    typedef struct packed {
        src_vec_t tdly;
        src_vec_t smp;
    } smp_state_t;

    typedef struct packed {
        logic     glb;
        src_vec_t en;
        src_vec_t pri;
        logic     act_hi;
        logic     act_lo;
    } ctl_state_t;
endpackage

// File: rtl/irqc_sampler.sv
module irqc_sampler
    import irqc_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     cyc_stb,
    input  src_vec_t src_req,
    input  src_vec_t clr_mask,
    output src_vec_t smp
);
    smp_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (cyc_stb) begin
            state_d.tdly = src_req & TMR_MASK;
            state_d.smp  = (src_req & ~TMR_MASK) | (state_q.tdly & TMR_MASK);
        end
        // acknowledge clear applied last so it wins over a coincident strobe
        state_d.smp = state_d.smp & ~clr_mask;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign smp = state_q.smp;
endmodule

// File: rtl/irqc_arbiter.sv
module irqc_arbiter
    import irqc_pkg::*;
(
    input  src_vec_t         smp,
    input  logic             glb,
    input  src_vec_t         en,
    input  src_vec_t         pri,
    input  logic             act_hi,
    input  logic             act_lo,
    output logic             req,
    output logic             grant_hi,
    output logic [IDXW-1:0]  idx,
    output logic [VECW-1:0]  vec
);
    src_vec_t pend, hi_c, lo_c, pick;

    always_comb begin
        pend     = smp & en & {NSRC{glb}};
        hi_c     = pend & pri & {NSRC{!act_hi}};
        lo_c     = pend & ~pri & {NSRC{!act_hi && !act_lo}};
        grant_hi = |hi_c;
        pick     = grant_hi ? hi_c : lo_c;
        req      = |pick;
        idx      = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (pick[i]) idx = IDXW'(i);
        end
        vec = req ? (VEC_BASE + VEC_STEP * VECW'(idx)) : '0;
    end
endmodule

// File: rtl/irq_enable_ctrl.sv
module irq_enable_ctrl
    import irqc_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cyc_stb,
    input  logic            reg_we,
    input  logic            reg_sel,
    input  logic [7:0]      reg_wdata,
    output logic [7:0]      reg_rdata,
    input  logic [4:0]      src_req,
    output logic            irq_req,
    output logic [15:0]     irq_vec,
    input  logic            irq_ack,
    input  logic            eos
);
    ctl_state_t      state_d, state_q;
    src_vec_t        smp, clr_mask;
    logic            grant_hi;
    logic [IDXW-1:0] idx;
    logic            take;
    logic [REGW-1:0] en_cur;
    logic            act_hi_cur, act_lo_cur;

    irqc_sampler u_smp (
        .clk      (clk),
        .rst_n    (rst_n),
        .cyc_stb  (cyc_stb),
        .src_req  (src_req),
        .clr_mask (clr_mask),
        .smp      (smp)
    );

    irqc_arbiter u_arb (
        .smp      (smp),
        .glb      (state_q.glb),
        .en       (state_q.en),
        .pri      (state_q.pri),
        .act_hi   (state_q.act_hi),
        .act_lo   (state_q.act_lo),
        .req      (irq_req),
        .grant_hi (grant_hi),
        .idx      (idx),
        .vec      (irq_vec)
    );

    assign take = irq_ack && irq_req;

    always_comb begin
        clr_mask = '0;
        if (take) clr_mask[idx] = 1'b1;
    end

    always_comb begin
        state_d = state_q;
        if (reg_we) begin
            if (!reg_sel) begin
                state_d.glb = reg_wdata[GLB_BIT];
                state_d.en  = reg_wdata[NSRC-1:0];
            end else begin
                state_d.pri = reg_wdata[NSRC-1:0];
            end
        end
        if (eos) begin
            if (state_q.act_hi) state_d.act_hi = 1'b0;
            else                state_d.act_lo = 1'b0;
        end
        if (take) begin
            if (grant_hi) state_d.act_hi = 1'b1;
            else          state_d.act_lo = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    always_comb begin
        en_cur          = '0;
        en_cur[GLB_BIT] = state_q.glb;
        en_cur[NSRC-1:0] = state_q.en;
        reg_rdata       = '0;
        if (!reg_sel) reg_rdata = en_cur;
        else          reg_rdata[NSRC-1:0] = state_q.pri;
    end

    assign act_hi_cur = state_q.act_hi;
    assign act_lo_cur = state_q.act_lo;
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_sel,
    input logic [7:0]  reg_rdata,
    input logic        irq_req,
    input logic [15:0] irq_vec,
    input logic        irq_ack,
    input logic        eos,
    input logic [7:0]  en_cur,
    input logic        act_hi,
    input logic        act_lo
);
    AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_sel |-> reg_rdata[6:5] == 2'b00); // R3

    AST_MASTER_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        !en_cur[7] |-> !irq_req); // R4

    AST_VEC_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (irq_vec[2:0] == 3'd3 && irq_vec[15:6] == '0 && irq_vec[5:3] <= 3'd4)); // R6

    AST_HI_NO_NEST: assert property (@(posedge clk) disable iff (!rst_n)
        act_hi |-> !irq_req); // R9

    AST_ACK_ENTERS: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && irq_ack) |=> (act_hi || act_lo)); // R9

    AST_STRAY_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_req && irq_ack && !eos) |=> ($stable(act_hi) && $stable(act_lo))); // R12
endmodule

bind irq_enable_ctrl irqc_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_sel   (reg_sel),
    .reg_rdata (reg_rdata),
    .irq_req   (irq_req),
    .irq_vec   (irq_vec),
    .irq_ack   (irq_ack),
    .eos       (eos),
    .en_cur    (en_cur),
    .act_hi    (act_hi_cur),
    .act_lo    (act_lo_cur)
);

// File: tb/sim_irq_enable_ctrl.sv
`timescale 1ns/1ps
module sim_irq_enable_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cyc_stb = 1'b0;
    logic        reg_we = 1'b0;
    logic        reg_sel = 1'b0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic [4:0]  src_req = '0;
    logic        irq_req;
    logic [15:0] irq_vec;
    logic        irq_ack = 1'b0;
    logic        eos = 1'b0;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    irq_enable_ctrl u0 (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic wr(input logic sel, input logic [7:0] d);
        reg_sel = sel; reg_wdata = d; reg_we = 1'b1;
        cyc();
        reg_we = 1'b0;
    endtask

    task automatic stb();
        cyc_stb = 1'b1;
        cyc();
        cyc_stb = 1'b0;
    endtask

    task automatic ack();
        irq_ack = 1'b1;
        cyc();
        irq_ack = 1'b0;
    endtask

    task automatic end_srv();
        eos = 1'b1;
        cyc();
        eos = 1'b0;
    endtask

    // expected {valid, vector} from requirements R4..R7, R9
    function automatic logic [16:0] model(input logic [4:0] r, input logic [7:0] e,
                                          input logic [4:0] p, input logic ah, input logic al);
        logic [16:0] res;
        res = '0;
        if (e[7] && !ah) begin
            for (int i = 4; i >= 0; i--)
                if (r[i] && e[i] && !p[i] && !al) res = {1'b1, 16'(3 + 8 * i)};
            for (int i = 4; i >= 0; i--)
                if (r[i] && e[i] && p[i]) res = {1'b1, 16'(3 + 8 * i)};
        end
        return res;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] ev;
        repeat (3) cyc();
        rst_n = 1'b1;
        cyc();
        // R1 reset state
        reg_sel = 1'b0; #0; cyc();
        chk("R1 enable reset", reg_rdata, 8'h00);
        reg_sel = 1'b1; cyc();
        chk("R1 priority reset", reg_rdata, 8'h00);
        chk("R1 no request", irq_req, 1'b0);

        // R2 R3 readback with reserved bits
        wr(1'b0, 8'hFF); reg_sel = 1'b0; cyc();
        chk("R3 enable reserved", reg_rdata, 8'h9F);
        wr(1'b1, 8'hFF); reg_sel = 1'b1; cyc();
        chk("R3 priority reserved", reg_rdata, 8'h1F);
        wr(1'b1, 8'h00);

        // R12 stray acknowledge
        wr(1'b0, 8'h9F);
        ack();
        src_req = 5'b00001; stb();
        chk("R12 stray ack no level", {irq_req, irq_vec}, {1'b1, 16'h0003});
        src_req = '0; stb();
        chk("R8 external gone after strobe", irq_req, 1'b0);

        // R8 timer delay and hold
        src_req = 5'b00010; stb();
        chk("R8 timer hidden after one strobe", irq_req, 1'b0);
        stb();
        chk("R8 timer after two strobes", {irq_req, irq_vec}, {1'b1, 16'h000B});
        src_req = '0; stb();
        chk("R8 timer held one strobe", {irq_req, irq_vec}, {1'b1, 16'h000B});
        stb();
        chk("R8 timer cleared", irq_req, 1'b0);

        // R9 R10 R11 nesting, serial high
        wr(1'b1, 8'h10);
        src_req = 5'b00001; stb();
        chk("R6 ext0 vector", {irq_req, irq_vec}, {1'b1, 16'h0003});
        ack();
        chk("R11 ack clears captured", irq_req, 1'b0);
        stb();
        chk("R9 low blocks low", irq_req, 1'b0);
        src_req = 5'b10001; stb();
        chk("R9 high preempts low", {irq_req, irq_vec}, {1'b1, 16'h0023});
        ack();
        chk("R9 high blocks all", irq_req, 1'b0);
        end_srv();
        chk("R10 eos retires high only", irq_req, 1'b0);
        end_srv();
        chk("R10 eos retires low", {irq_req, irq_vec}, {1'b1, 16'h0003});

        // R11 ack coinciding with strobe
        src_req = 5'b00001;
        irq_ack = 1'b1; cyc_stb = 1'b1; cyc();
        irq_ack = 1'b0; cyc_stb = 1'b0;
        end_srv();
        chk("R11 clear wins over strobe", irq_req, 1'b0);
        stb();
        chk("R11 request back next strobe", {irq_req, irq_vec}, {1'b1, 16'h0003});

        // R6 R7 sweep: all priorities x all patterns
        wr(1'b0, 8'h9F);
        for (int p = 0; p < 32; p++) begin
            wr(1'b1, 8'(p));
            for (int r = 0; r < 32; r++) begin
                src_req = 5'(r); stb(); stb();
                chk("R6 R7 sweep", {15'b0, irq_req, irq_vec},
                    {15'b0, model(5'(r), 8'h9F, 5'(p), 1'b0, 1'b0)});
            end
        end

        // R2 R4 R5 sweep: all enables x all patterns
        wr(1'b1, 8'h00);
        for (int e = 0; e < 64; e++) begin
            ev = {e[5], 2'b00, e[4:0]};
            wr(1'b0, {e[5], 2'b11, e[4:0]});
            reg_sel = 1'b0; cyc();
            chk("R2 enable readback", reg_rdata, ev);
            for (int r = 0; r < 32; r++) begin
                src_req = 5'(r); stb(); stb();
                chk("R4 R5 sweep", {15'b0, irq_req, irq_vec},
                    {15'b0, model(5'(r), ev, 5'b0, 1'b0, 1'b0)});
            end
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule